// File: doc/BRIEF.md
# Serial Configuration Chain Forwarder

This block sits in a chain of devices that are loaded from one shared serial stream. Each device keeps the first part of the stream for itself and passes the rest on to the next device in the chain. Bits arrive on `din` and are sampled on the rising edge of `cclk`. A counter tracks how many bits this device has taken. Once the counter reaches the parameter `LOCAL_BITS`, later bits are sent out again on `dout`. The output is retimed so that it changes on a falling edge, one and a half clock periods after the bit was sampled.

The static input `expressMode` selects a second way of working. In express mode `dout` carries no data. It becomes the enable line for the next device: low while this device is still loading, and high once the local count is complete. Also in express mode, the `serialEn` input decides on each rising edge whether this device takes a bit. `expressMode` is a strap. It may only change while `rstN` is low.

Top module: `cfgfwd_chain`

## Requirements
- R1: In serial mode (`expressMode` = 0), every rising edge of `cclk` outside reset samples `din` and counts one bit. `serialEn` has no effect in this mode.
- R2: `dout` never changes at a rising edge of `cclk`. It changes only after a falling edge, or at the assertion of reset.
- R3: In serial mode, a forwarded bit sampled at rising edge k is driven on `dout` from the falling edge that follows rising edge k+1. That is 1.5 clock periods, and the bit is not visible earlier.
- R4: In serial mode, the bits sampled while the count is below `LOCAL_BITS` are kept locally, and `dout` shows 1 in their output slots.
- R5: In serial mode, every bit sampled once the count equals `LOCAL_BITS` is forwarded unchanged. There is no limit on how many bits are forwarded.
- R6: In express mode, `dout` is 0 until the local count completes. It goes to 1 at the falling edge 1.5 periods after the rising edge that took the last local bit, and it stays at 1.
- R7: In express mode, a rising edge with `serialEn` = 0 takes no bit and leaves the count unchanged.
- R8: `rstN` low asynchronously clears the count and the retiming pipeline. While reset is held, `dout` is 1 in serial mode and 0 in express mode.
- R9: The bit count saturates at `LOCAL_BITS` and never wraps, however many bits follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cclk | input | 1 | Configuration clock |
| rstN | input | 1 | Asynchronous active-low reset |
| expressMode | input | 1 | 0: serial forwarding, 1: express (dout is downstream enable) |
| serialEn | input | 1 | Express-mode receive enable, ignored in serial mode |
| din | input | 1 | Serial data in, sampled on rising edge |
| dout | output | 1 | Forwarded data (serial) or downstream enable (express) |

## Verification
The first corner case is the boundary between local and forwarded bits. A count that is off by one would let the last local bit leak onto `dout`, or would swallow the first forwarded bit. Random data that contains zeros exposes both faults, because a held-high slot then differs from the data slot.

Latency is checked by sampling just after each rising edge and just after each falling edge. A design that retimed by one or two whole periods, or on the wrong edge, would show the bit one half-period early or late.

In express mode, long stretches with `serialEn` low show whether the enable really gates counting: a design that ignored it would raise `dout` too soon. A reset in the middle of forwarding shows whether stale pipeline bits survive reset.

// File: rtl/cfgfwd_pkg.sv
package cfgfwd_pkg;

  // Strobes from the control side, qualified for the bit sampled this edge.
  typedef struct packed {
    logic accept;   // this rising edge takes a bit
    logic forward;  // the bit sampled now belongs downstream
    logic done;     // local count is complete once this edge is taken
  } ctlStrobe_t;

  // One slot of the retiming pipeline.
  typedef struct packed {
    logic data;
    logic forward;
    logic done;
  } pipeSlot_t;

endpackage

// File: rtl/cfgfwd_ctrl.sv
module cfgfwd_ctrl
  import cfgfwd_pkg::*;
#(
  parameter int LOCAL_BITS = 16,
  localparam int CW = $clog2(LOCAL_BITS + 1)
) (
  input  logic       cclk,
  input  logic       rstN,
  input  logic       expressMode,
  input  logic       serialEn,
  output logic [CW-1:0] bitCount,
  output ctlStrobe_t strobe
);

  localparam logic [CW-1:0] FULL   = CW'(LOCAL_BITS);
  localparam logic [CW-1:0] LAST   = CW'(LOCAL_BITS - 1);

  logic [CW-1:0] countQ;
  logic          isFull;
  logic          takeBit;

  assign isFull  = (countQ == FULL);
  assign takeBit = expressMode ? serialEn : 1'b1;

  always_comb begin
    strobe.accept  = takeBit;
    strobe.forward = isFull;
    strobe.done    = isFull || (takeBit && (countQ == LAST));
  end

  always_ff @(posedge cclk or negedge rstN) begin
    if (!rstN) begin
      countQ <= '0;
    end else if (takeBit && !isFull) begin
      countQ <= countQ + 1'b1;
    end
  end

  assign bitCount = countQ;

endmodule

// File: rtl/cfgfwd_dpath.sv
module cfgfwd_dpath
  import cfgfwd_pkg::*;
#(
  parameter int RISE_STAGES = 2
) (
  input  logic       cclk,
  input  logic       rstN,
  input  logic       expressMode,
  input  logic       din,
  input  ctlStrobe_t strobe,
  output logic       dout
);

  pipeSlot_t stageQ [RISE_STAGES];
  pipeSlot_t fallQ;
  pipeSlot_t entry;

  always_comb begin
    entry.data    = din;
    entry.forward = strobe.forward;
    entry.done    = strobe.done;
  end

  // Rising-edge stages: one whole period of delay per stage after the sample.
  for (genvar s = 0; s < RISE_STAGES; s++) begin : g_rise
    always_ff @(posedge cclk or negedge rstN) begin
      if (!rstN) begin
        stageQ[s] <= '0;
      end else if (s == 0) begin
        stageQ[s] <= entry;
      end else begin
        stageQ[s] <= stageQ[(s == 0) ? 0 : s - 1];
      end
    end
  end

  // Falling-edge output register adds the final half period.
  always_ff @(negedge cclk or negedge rstN) begin
    if (!rstN) begin
      fallQ <= '0;
    end else begin
      fallQ <= stageQ[RISE_STAGES-1];
    end
  end

  always_comb begin
    if (expressMode) begin
      dout = fallQ.done;
    end else begin
      dout = fallQ.forward ? fallQ.data : 1'b1;
    end
  end

endmodule

// File: rtl/cfgfwd_chain.sv
module cfgfwd_chain
  import cfgfwd_pkg::*;
#(
  parameter int LOCAL_BITS = 16
) (
  input  logic cclk,
  input  logic rstN,
  input  logic expressMode,
  input  logic serialEn,
  input  logic din,
  output logic dout
);

  localparam int CW = $clog2(LOCAL_BITS + 1);

  logic [CW-1:0] bitCount;
  ctlStrobe_t    strobe;

  cfgfwd_ctrl #(.LOCAL_BITS(LOCAL_BITS)) uCtrl (
    .cclk        (cclk),
    .rstN        (rstN),
    .expressMode (expressMode),
    .serialEn    (serialEn),
    .bitCount    (bitCount),
    .strobe      (strobe)
  );

  // Two rising stages plus the falling register give the 1.5 period delay.
  cfgfwd_dpath #(.RISE_STAGES(2)) uDpath (
    .cclk        (cclk),
    .rstN        (rstN),
    .expressMode (expressMode),
    .din         (din),
    .strobe      (strobe),
    .dout        (dout)
  );

endmodule

// File: rtl/cfgfwd_chain_chk.sv
module cfgfwd_chain_chk
  import cfgfwd_pkg::*;
#(
  parameter int LOCAL_BITS = 16,
  localparam int CW = $clog2(LOCAL_BITS + 1)
) (
  input logic          cclk,
  input logic          rstN,
  input logic          expressMode,
  input logic          serialEn,
  input logic          din,
  input logic          dout,
  input logic [CW-1:0] bitCount,
  input ctlStrobe_t    strobe
);

  logic [1:0] warm;

  always_ff @(posedge cclk or negedge rstN) begin
    if (!rstN) warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  // R3 R5: forwarded bit reaches dout 1.5 periods later
  a_r5_serial_forward: assert property (@(posedge cclk) disable iff (!rstN)
    (warm >= 2'd2 && !expressMode && $past(strobe.forward, 2)) |-> (dout == $past(din, 2)));

  // R4: local bits show as 1
  a_r4_serial_hold: assert property (@(posedge cclk) disable iff (!rstN)
    (warm >= 2'd2 && !expressMode && !$past(strobe.forward, 2)) |-> dout);

  // R6: express output follows completion with the same latency
  a_r6_express_enable: assert property (@(posedge cclk) disable iff (!rstN)
    (warm >= 2'd2 && expressMode) |-> (dout == $past(strobe.done, 2)));

  // R7: no bit taken while express receive is disabled
  a_r7_express_gate: assert property (@(posedge cclk) disable iff (!rstN)
    (expressMode && !serialEn) |=> $stable(bitCount));

  // R9: count never passes the local size
  a_r9_no_overflow: assert property (@(posedge cclk) disable iff (!rstN)
    bitCount <= CW'(LOCAL_BITS));

  // R1: serial mode takes a bit on every edge until full
  a_r1_serial_count: assert property (@(posedge cclk) disable iff (!rstN)
    (!expressMode && bitCount != CW'(LOCAL_BITS)) |=> (bitCount == $past(bitCount) + 1'b1));

  // R8: idle level while reset is held
  a_r8_reset_idle: assert property (@(posedge cclk)
    !rstN |-> (dout == !expressMode));

endmodule

bind cfgfwd_chain cfgfwd_chain_chk #(.LOCAL_BITS(LOCAL_BITS)) uChk (
  .cclk        (cclk),
  .rstN        (rstN),
  .expressMode (expressMode),
  .serialEn    (serialEn),
  .din         (din),
  .dout        (dout),
  .bitCount    (bitCount),
  .strobe      (strobe)
);

// File: tb/sim_cfgfwd_chain.sv
module sim_cfgfwd_chain;

  localparam int LB = 16;

  logic cclk = 1'b0;
  logic rstN;
  logic expressMode;
  logic serialEn;
  logic din;
  logic dout;

  int compared = 0;
  int mismatched = 0;

  // behavioural model state
  int    modelCount;
  int    pipeA, pipeB;
  string tagA, tagB;
  logic  lastFall;

  cfgfwd_chain #(.LOCAL_BITS(LB)) u0 (
    .cclk(cclk), .rstN(rstN), .expressMode(expressMode),
    .serialEn(serialEn), .din(din), .dout(dout)
  );

  always #4 cclk = ~cclk;

  task automatic check(input string tag, input logic act, input logic expv);
    compared++;
    if (act !== expv) begin
      mismatched++;
      $display("FAIL %s at %0t: dout=%b expected=%b", tag, $time, act, expv);
    end
  endtask

  function automatic int idleLevel();
    return expressMode ? 0 : 1;
  endfunction

  // R8: assert reset, select mode, check idle level, release on next cycle
  task automatic doReset(input logic mode);
    rstN = 1'b0;
    expressMode = mode;
    #1;
    check("R8", dout, logic'(idleLevel()));
    modelCount = 0;
    pipeA = idleLevel(); pipeB = idleLevel();
    tagA = "R8"; tagB = "R8";
    lastFall = logic'(idleLevel());
    @(posedge cclk);
    #2 rstN = 1'b1;
  endtask

  // One clock: model samples the pins as the design does, then checks.
  task automatic cycle(input logic nextDin, input logic nextEn);
    int    expv;
    string expTag;
    int    item;
    string itemTag;
    bit    acc, fwd;
    @(posedge cclk);
    expv = pipeB; expTag = tagB;
    acc = expressMode ? serialEn : 1'b1;       // R1 R7
    fwd = (modelCount == LB);
    if (acc && modelCount < LB) modelCount++;  // R9 saturation
    if (expressMode) begin
      item = (modelCount == LB) ? 1 : 0;       // R6
      itemTag = "R6 R7";
    end else if (fwd) begin
      item = din;                              // R5 R3
      itemTag = "R5 R3";
    end else begin
      item = 1;                                // R4 R1
      itemTag = "R4 R1";
    end
    pipeB = pipeA; tagB = tagA;
    pipeA = item;  tagA = itemTag;
    #1;
    check("R2", dout, lastFall);
    check(expTag, dout, logic'(expv));
    #1;
    din = nextDin;
    serialEn = nextEn;
    @(negedge cclk);
    #1 lastFall = dout;
  endtask

  initial begin
    #(8 * 200000);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rstN = 1'b1; expressMode = 1'b0; serialEn = 1'b0; din = 1'b0;
    #1;
    // serial mode, random data, serialEn toggled (ignored, R1)
    doReset(1'b0);
    for (int i = 0; i < 40; i++) cycle(logic'($urandom_range(0, 1)), logic'($urandom_range(0, 1)));
    // zeros and alternating patterns make hold-high vs forward visible (R4 R5)
    for (int i = 0; i < 12; i++) cycle(1'b0, 1'b0);
    for (int i = 0; i < 12; i++) cycle(logic'(i % 2), 1'b1);
    // reset in the middle of forwarding (R8), then restart serial
    doReset(1'b0);
    for (int i = 0; i < 30; i++) cycle(1'b0, 1'b1);
    // express mode: long disabled stretch (R7), then random enables (R6)
    doReset(1'b1);
    for (int i = 0; i < 25; i++) cycle(logic'($urandom_range(0, 1)), 1'b0);
    for (int i = 0; i < 70; i++) cycle(logic'($urandom_range(0, 1)), logic'($urandom_range(0, 1)));
    // express mode, steady enable: exact completion edge (R6)
    doReset(1'b1);
    for (int i = 0; i < 30; i++) cycle(1'b1, 1'b1);
    // long serial run past saturation (R9 R5)
    doReset(1'b0);
    for (int i = 0; i < 300; i++) cycle(logic'($urandom_range(0, 1)), logic'($urandom_range(0, 1)));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule